// File: doc/BRIEF.md
# Interrupt Priority Selector

This block keeps the lifecycle state of every interrupt source seen by one processor and decides which source goes to that processor next. The ID space is split in two groups. IDs 0 to 31 are private to the processor: the lower sixteen are software-generated and the upper sixteen are peripheral. IDs from 32 up to 32+NUM_SPI-1 are shared sources. A source moves through four states: idle, pending, active, and active with a fresh request behind it. It is pending in the second and fourth states and active in the third and fourth.

Requests come in as one-cycle raise and drop strobes that carry an ID. A configuration port writes the enable bit and 8-bit priority of one ID at a time. A lower priority value means a more urgent source. The block owns one presentation slot. The slot holds ID 1023 when nothing is presented. When the slot is empty, the most urgent enabled pending source is moved into it and marked active. When the processor signals that it has finished with that source, the source is dropped, the slot empties again, and the block sends out a completion pulse carrying the ID.

Top module: `irqPrioritySelector`

## Requirements
- R1: After reset, presentedId is 1023, irqPending and eoiValid are low, and every source is idle and disabled with priority 0. Enabling a source while it is idle does not present it.
- R2: A raise strobe on an idle, enabled source while the slot is empty sets presentedId to that ID and irqPending high on the second clock edge after the strobe. presentedId has not yet changed after the first edge.
- R3: A raise strobe on a source that is already pending leaves it unchanged, so one drop strobe returns it to idle.
- R4: A disabled pending source is never selected. It is selected once its enable bit is written to 1 while the slot is empty.
- R5: Within one group (IDs 0–31, or IDs 32 and up), the lowest priority value wins. Among equal values, the lowest ID wins.
- R6: The shared winner is presented only if there is no private winner, or if the private winner's priority value is strictly larger. Equal values go to the private source.
- R7: While presentedId is not 1023 and no completion arrives, presentedId holds its value, irqPending stays high, and no other source is selected.
- R8: A completion pulse while the slot is full drops the presented source to idle. From the next edge, presentedId reads 1023 and irqPending is low, and the dropped source is not presented again unless it is raised again.
- R9: A drop strobe on a source that is not idle makes it idle. One edge later, eoiValid is high for exactly one cycle and eoiId carries the ID. A drop strobe on an idle source raises no eoiValid.
- R10: A completion pulse takes the single drop path in its cycle. A drop strobe given in the same cycle is ignored, and the source it names keeps its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setReq | input | 1 | Raise strobe |
| setId | input | 10 | ID to raise |
| clrReq | input | 1 | Drop strobe |
| clrId | input | 10 | ID to drop |
| cfgWe | input | 1 | Configuration write strobe |
| cfgId | input | 10 | ID being configured |
| cfgEnable | input | 1 | Enable bit to write |
| cfgPrio | input | 8 | Priority to write (lower is more urgent) |
| doneValid | input | 1 | Processor has finished with the presented source |
| presentedId | output | 10 | Presented ID, 1023 when empty |
| irqPending | output | 1 | High while the slot holds a source |
| eoiValid | output | 1 | Completion pulse |
| eoiId | output | 10 | ID of the completed source |

## Verification
Results arrive at fixed delays:
- A drop strobe or completion pulse shows on eoiValid and eoiId one edge later.
- A completion empties the slot at that same edge.
- A raise strobe or an enable write becomes a selection two edges later, because the source state register and then the slot register must each be written.

Inputs are driven at falling edges. Completion effects are sampled at the first falling edge after the strobe. Selection effects are sampled at the second falling edge after the strobe or later, and the table walk always waits three falling edges so that any follow-on selection has settled.

// File: rtl/irqSelPkg.sv
package irqSelPkg;
  localparam int ID_W = 10;
  localparam int PRIO_W = 8;
  localparam int PRIVATE_COUNT = 32;
  localparam logic [ID_W-1:0] NO_IRQ = 10'd1023;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PEND    = 2'd1,
    ST_ACT     = 2'd2,
    ST_ACTPEND = 2'd3
  } irqState_e;

  // strobes from slot control to the state bank
  typedef struct packed {
    logic            take;
    logic            clrEn;
    logic [ID_W-1:0] clrId;
  } ctrlStrobe_t;
endpackage

// File: rtl/irqPickBest.sv
module irqPickBest
  import irqSelPkg::*;
#(
  parameter int BASE  = 0,
  parameter int COUNT = 32
) (
  input  logic [COUNT-1:0]             cand,
  input  logic [COUNT-1:0][PRIO_W-1:0] prio,
  output logic                         found,
  output logic [ID_W-1:0]              bestId,
  output logic [PRIO_W-1:0]            bestPrio
);
  // scan from the top down so equal priorities settle on the lowest ID
  always_comb begin
    found    = 1'b0;
    bestId   = NO_IRQ;
    bestPrio = '0;
    for (int i = COUNT - 1; i >= 0; i--) begin
      if (cand[i] && (!found || prio[i] <= bestPrio)) begin
        found    = 1'b1;
        bestId   = ID_W'(BASE + i);
        bestPrio = prio[i];
      end
    end
  end
endmodule

// File: rtl/irqStateBank.sv
module irqStateBank
  import irqSelPkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setReq,
  input  logic [ID_W-1:0]   setId,
  input  logic              cfgWe,
  input  logic [ID_W-1:0]   cfgId,
  input  logic              cfgEnable,
  input  logic [PRIO_W-1:0] cfgPrio,
  input  ctrlStrobe_t       strobe,
  output logic              candValid,
  output logic [ID_W-1:0]   candId,
  output logic              clrEffective
);
  localparam int SHARED_COUNT = NUM_IRQ - PRIVATE_COUNT;
  localparam int IDX_W = $clog2(NUM_IRQ);

  irqState_e stateQ [NUM_IRQ];
  irqState_e stateD [NUM_IRQ];
  logic [NUM_IRQ-1:0]             enQ;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] prioQ;
  logic [NUM_IRQ-1:0]             cand;

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      cand[i] = enQ[i] && (stateQ[i] == ST_PEND || stateQ[i] == ST_ACTPEND);
    end
  end

  logic              pvFound, shFound;
  logic [ID_W-1:0]   pvId, shId;
  logic [PRIO_W-1:0] pvPrio, shPrio;

  irqPickBest #(.BASE(0), .COUNT(PRIVATE_COUNT)) pickPrivate (
    .cand(cand[PRIVATE_COUNT-1:0]), .prio(prioQ[PRIVATE_COUNT-1:0]),
    .found(pvFound), .bestId(pvId), .bestPrio(pvPrio)
  );

  irqPickBest #(.BASE(PRIVATE_COUNT), .COUNT(SHARED_COUNT)) pickShared (
    .cand(cand[NUM_IRQ-1:PRIVATE_COUNT]), .prio(prioQ[NUM_IRQ-1:PRIVATE_COUNT]),
    .found(shFound), .bestId(shId), .bestPrio(shPrio)
  );

  // ties between the groups go to the private source
  logic useShared;
  assign useShared = shFound && (!pvFound || pvPrio > shPrio);
  assign candValid = pvFound || shFound;
  assign candId    = useShared ? shId : pvId;

  logic clrInRange;
  assign clrInRange   = strobe.clrId < ID_W'(NUM_IRQ);
  assign clrEffective = clrInRange && (stateQ[strobe.clrId[IDX_W-1:0]] != ST_IDLE);

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      logic isPend;
      isPend = (stateQ[i] == ST_PEND) || (stateQ[i] == ST_ACTPEND);
      stateD[i] = stateQ[i];
      if (strobe.take && candId == ID_W'(i)) stateD[i] = ST_ACT;
      if (setReq && setId == ID_W'(i) && !isPend)
        stateD[i] = (stateQ[i] == ST_ACT) ? ST_ACTPEND : ST_PEND;
      if (strobe.clrEn && strobe.clrId == ID_W'(i)) stateD[i] = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_IRQ; i++) stateQ[i] <= ST_IDLE;
      enQ   <= '0;
      prioQ <= '0;
    end else begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        stateQ[i] <= stateD[i];
        if (cfgWe && cfgId == ID_W'(i)) begin
          enQ[i]   <= cfgEnable;
          prioQ[i] <= cfgPrio;
        end
      end
    end
  end
endmodule

// File: rtl/irqSlotCtrl.sv
module irqSlotCtrl
  import irqSelPkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            doneValid,
  input  logic            clrReq,
  input  logic [ID_W-1:0] clrId,
  input  logic            candValid,
  input  logic [ID_W-1:0] candId,
  input  logic            clrEffective,
  output ctrlStrobe_t     strobe,
  output logic [ID_W-1:0] presentedId,
  output logic            irqPending,
  output logic            eoiValid,
  output logic [ID_W-1:0] eoiId
);
  logic [ID_W-1:0] slotQ;
  logic slotEmpty, doneHit;

  assign slotEmpty    = slotQ == NO_IRQ;
  assign doneHit      = doneValid && !slotEmpty;
  assign strobe.take  = slotEmpty && candValid;
  assign strobe.clrEn = doneHit || clrReq;
  assign strobe.clrId = doneHit ? slotQ : clrId;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slotQ    <= NO_IRQ;
      eoiValid <= 1'b0;
      eoiId    <= NO_IRQ;
    end else begin
      if (doneHit)          slotQ <= NO_IRQ;
      else if (strobe.take) slotQ <= candId;
      eoiValid <= strobe.clrEn && clrEffective;
      if (strobe.clrEn) eoiId <= strobe.clrId;
    end
  end

  assign presentedId = slotQ;
  assign irqPending  = !slotEmpty;
endmodule

// File: rtl/irqPrioritySelector.sv
module irqPrioritySelector
  import irqSelPkg::*;
#(
  parameter int NUM_SPI = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setReq,
  input  logic [ID_W-1:0]   setId,
  input  logic              clrReq,
  input  logic [ID_W-1:0]   clrId,
  input  logic              cfgWe,
  input  logic [ID_W-1:0]   cfgId,
  input  logic              cfgEnable,
  input  logic [PRIO_W-1:0] cfgPrio,
  input  logic              doneValid,
  output logic [ID_W-1:0]   presentedId,
  output logic              irqPending,
  output logic              eoiValid,
  output logic [ID_W-1:0]   eoiId
);
  localparam int NUM_IRQ = PRIVATE_COUNT + NUM_SPI;

  ctrlStrobe_t     strobe;
  logic            candValid, clrEffective;
  logic [ID_W-1:0] candId;

  irqStateBank #(.NUM_IRQ(NUM_IRQ)) bank (
    .clk(clk), .rst_n(rst_n), .setReq(setReq), .setId(setId),
    .cfgWe(cfgWe), .cfgId(cfgId), .cfgEnable(cfgEnable), .cfgPrio(cfgPrio),
    .strobe(strobe), .candValid(candValid), .candId(candId),
    .clrEffective(clrEffective)
  );

  irqSlotCtrl ctrl (
    .clk(clk), .rst_n(rst_n), .doneValid(doneValid), .clrReq(clrReq),
    .clrId(clrId), .candValid(candValid), .candId(candId),
    .clrEffective(clrEffective), .strobe(strobe), .presentedId(presentedId),
    .irqPending(irqPending), .eoiValid(eoiValid), .eoiId(eoiId)
  );
endmodule

// File: rtl/irqSelChecker.sv
module irqSelChecker
  import irqSelPkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            clrReq,
  input logic            doneValid,
  input logic [ID_W-1:0] presentedId,
  input logic            irqPending,
  input logic            eoiValid,
  input logic [ID_W-1:0] eoiId
);
  assert_slot_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (presentedId != NO_IRQ && !doneValid) |=> $stable(presentedId));

  assert_flag_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (presentedId != NO_IRQ && !doneValid) |=> irqPending);

  assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (doneValid && presentedId != NO_IRQ) |=> (presentedId == NO_IRQ && !irqPending));

  assert_eoi_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eoiValid |-> $past(clrReq || doneValid));

  assert_done_owns_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (doneValid && presentedId != NO_IRQ) |=> eoiId == $past(presentedId));
endmodule

bind irqPrioritySelector irqSelChecker chk (
  .clk(clk), .rst_n(rst_n), .clrReq(clrReq), .doneValid(doneValid),
  .presentedId(presentedId), .irqPending(irqPending),
  .eoiValid(eoiValid), .eoiId(eoiId)
);

// File: tb/irqPrioritySelector_test.sv
`timescale 1ns/1ps
module irqPrioritySelector_test;
  localparam logic [9:0] NONE = 10'd1023;
  localparam logic [1:0] OP_CFG = 2'd0, OP_SET = 2'd1, OP_CLR = 2'd2, OP_DONE = 2'd3;

  typedef struct packed {
    logic [1:0] op;
    logic [9:0] id;
    logic       en;
    logic [7:0] prio;
    logic [9:0] expId;
    logic       expPend;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{OP_CFG, 10'd5, 1'b1, 8'd8, NONE, 1'b0, 4'd1},     // R1 enable alone presents nothing
    '{OP_CFG, 10'd40, 1'b1, 8'd4, NONE, 1'b0, 4'd1},
    '{OP_CFG, 10'd7, 1'b1, 8'd8, NONE, 1'b0, 4'd1},
    '{OP_CFG, 10'd20, 1'b1, 8'd4, NONE, 1'b0, 4'd1},
    '{OP_CFG, 10'd50, 1'b0, 8'd1, NONE, 1'b0, 4'd1},
    '{OP_SET, 10'd50, 1'b0, 8'd0, NONE, 1'b0, 4'd4},    // R4 disabled skipped
    '{OP_SET, 10'd7, 1'b0, 8'd0, 10'd7, 1'b1, 4'd2},    // R2
    '{OP_SET, 10'd5, 1'b0, 8'd0, 10'd7, 1'b1, 4'd7},    // R7 slot held
    '{OP_SET, 10'd40, 1'b0, 8'd0, 10'd7, 1'b1, 4'd7},
    '{OP_DONE, 10'd0, 1'b0, 8'd0, 10'd40, 1'b1, 4'd6},  // R6 shared more urgent
    '{OP_SET, 10'd20, 1'b0, 8'd0, 10'd40, 1'b1, 4'd7},
    '{OP_DONE, 10'd0, 1'b0, 8'd0, 10'd20, 1'b1, 4'd5},  // R5 lower value wins
    '{OP_SET, 10'd40, 1'b0, 8'd0, 10'd20, 1'b1, 4'd7},
    '{OP_DONE, 10'd0, 1'b0, 8'd0, 10'd40, 1'b1, 4'd6},
    '{OP_CFG, 10'd5, 1'b1, 8'd4, 10'd40, 1'b1, 4'd7},
    '{OP_CFG, 10'd44, 1'b1, 8'd4, 10'd40, 1'b1, 4'd7},
    '{OP_SET, 10'd44, 1'b0, 8'd0, 10'd40, 1'b1, 4'd7},
    '{OP_DONE, 10'd0, 1'b0, 8'd0, 10'd5, 1'b1, 4'd6},   // R6 tie to private
    '{OP_DONE, 10'd0, 1'b0, 8'd0, 10'd44, 1'b1, 4'd6},
    '{OP_DONE, 10'd0, 1'b0, 8'd0, NONE, 1'b0, 4'd4},    // R4 still disabled
    '{OP_CFG, 10'd50, 1'b1, 8'd1, 10'd50, 1'b1, 4'd4},  // R4 enable presents
    '{OP_CFG, 10'd9, 1'b1, 8'd6, 10'd50, 1'b1, 4'd7},
    '{OP_CFG, 10'd3, 1'b1, 8'd6, 10'd50, 1'b1, 4'd7},
    '{OP_SET, 10'd9, 1'b0, 8'd0, 10'd50, 1'b1, 4'd7},
    '{OP_SET, 10'd3, 1'b0, 8'd0, 10'd50, 1'b1, 4'd7},
    '{OP_DONE, 10'd0, 1'b0, 8'd0, 10'd3, 1'b1, 4'd5},   // R5 tie to lower ID
    '{OP_DONE, 10'd0, 1'b0, 8'd0, 10'd9, 1'b1, 4'd5},
    '{OP_DONE, 10'd0, 1'b0, 8'd0, NONE, 1'b0, 4'd8}     // R8 empty again
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic setReq = 0, clrReq = 0, cfgWe = 0, cfgEnable = 0, doneValid = 0;
  logic [9:0] setId = '0, clrId = '0, cfgId = '0;
  logic [7:0] cfgPrio = '0;
  logic [9:0] presentedId, eoiId;
  logic irqPending, eoiValid;
  int testCount = 0, failCount = 0;

  always #2 clk = ~clk;

  irqPrioritySelector uut (
    .clk(clk), .rst_n(rst_n), .setReq(setReq), .setId(setId),
    .clrReq(clrReq), .clrId(clrId), .cfgWe(cfgWe), .cfgId(cfgId),
    .cfgEnable(cfgEnable), .cfgPrio(cfgPrio), .doneValid(doneValid),
    .presentedId(presentedId), .irqPending(irqPending),
    .eoiValid(eoiValid), .eoiId(eoiId)
  );

  task automatic check(input string tag, input int actual, input int expected);
    testCount++;
    if (actual != expected) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  // each pulse task starts and ends at a falling edge
  task automatic doCfg(input int id, input logic en, input int p);
    cfgWe = 1; cfgId = 10'(id); cfgEnable = en; cfgPrio = 8'(p);
    @(negedge clk); cfgWe = 0;
  endtask
  task automatic doSet(input int id);
    setReq = 1; setId = 10'(id);
    @(negedge clk); setReq = 0;
  endtask
  task automatic doClr(input int id);
    clrReq = 1; clrId = 10'(id);
    @(negedge clk); clrReq = 0;
  endtask
  task automatic doDone();
    doneValid = 1;
    @(negedge clk); doneValid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCount++; testCount++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset presentedId", presentedId, NONE);
    check("R1 reset irqPending", irqPending, 0);
    check("R1 reset eoiValid", eoiValid, 0);

    for (int k = 0; k < NV; k++) begin
      case (VECS[k].op)
        OP_CFG:  doCfg(VECS[k].id, VECS[k].en, VECS[k].prio);
        OP_SET:  doSet(VECS[k].id);
        OP_CLR:  doClr(VECS[k].id);
        default: doDone();
      endcase
      repeat (2) @(negedge clk);
      check($sformatf("R%0d vector %0d presentedId", VECS[k].req, k), presentedId, VECS[k].expId);
      check($sformatf("R%0d vector %0d irqPending", VECS[k].req, k), irqPending, VECS[k].expPend);
    end

    // R9: drop of a pending source, then of an idle one
    doSet(12);
    @(negedge clk);
    doClr(12);
    check("R9 eoiValid after drop", eoiValid, 1);
    check("R9 eoiId after drop", eoiId, 12);
    @(negedge clk);
    check("R9 eoiValid single cycle", eoiValid, 0);
    doClr(12);
    check("R9 idle drop no eoi", eoiValid, 0);

    // R2: exact selection latency
    doCfg(13, 1'b1, 2);
    doSet(13);
    check("R2 not after first edge", presentedId, NONE);
    @(negedge clk);
    check("R2 presentedId after second edge", presentedId, 13);
    check("R2 irqPending", irqPending, 1);

    // R8: completion
    doDone();
    check("R8 slot empty", presentedId, NONE);
    check("R8 irqPending low", irqPending, 0);
    check("R8 eoiValid", eoiValid, 1);
    check("R8 eoiId", eoiId, 13);
    repeat (3) @(negedge clk);
    check("R8 not presented again", presentedId, NONE);

    // R10: completion and drop in the same cycle
    doSet(14);
    doSet(13);
    repeat (2) @(negedge clk);
    check("R10 presented before", presentedId, 13);
    doneValid = 1; clrReq = 1; clrId = 10'd14;
    @(negedge clk); doneValid = 0; clrReq = 0;
    check("R10 eoiId is completion", eoiId, 13);
    doClr(14);
    check("R10 ignored drop left source pending", eoiValid, 1);
    check("R10 eoiId later drop", eoiId, 14);

    // R3: repeated raise on a pending source
    doCfg(15, 1'b0, 3);
    doSet(15);
    doSet(15);
    doClr(15);
    check("R3 first drop eoi", eoiValid, 1);
    doClr(15);
    check("R3 second drop no eoi", eoiValid, 0);
    doCfg(15, 1'b1, 3);
    repeat (3) @(negedge clk);
    check("R3 nothing left pending", presentedId, NONE);

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule